// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Partial Flags

This block buffers bytes between a producer and a consumer that run on separate clocks. The two clocks may be one shared clock or may be unrelated. A byte is stored on each rising write-clock edge while the write enable is held low. A byte is moved into an output register on each rising read-clock edge while the read enable is held low. When the output enable is high, the output bus goes to high impedance.

Four active-low flags report the fill state. Empty and almost-empty are produced in the read domain. Full and almost-full are produced in the write domain. Each domain sees the other side's pointer a few cycles late, so a flag may release late, but it never claims room or data that is not there. The depth is a power-of-two parameter from 64 to 4096 words.

Top module: `async_byte_fifo`

## Requirements
- R1: While `wr_en_n` is low and `full_n` is high, each rising `wr_clk` edge stores `wr_data`, and bytes leave in the order they were stored.
- R2: A write attempted while `full_n` is low stores nothing and leaves the stored contents and their order unchanged.
- R3: While `rd_en_n` is low and `empty_n` is high, each rising `rd_clk` edge loads the oldest stored byte into the output register. A read while `empty_n` is low does nothing.
- R4: The output register keeps its value until the next accepted read. It holds 0 after reset.
- R5: While `rst_n` is low, both pointers return to location 0, `full_n` and `afull_n` are high, and `empty_n` and `aempty_n` are low.
- R6: `empty_n` is never high while the buffer holds no bytes. Once the write side has been idle for a few read clocks, it is high exactly when at least one byte is stored.
- R7: `aempty_n` is never high while 7 or fewer bytes are stored. Once settled, it is low exactly when the fill level is 7 or less.
- R8: `afull_n` is never high while DEPTH-7 or more bytes are stored. Once settled, it is low exactly when the fill level is DEPTH-7 or more.
- R9: `full_n` is never high while DEPTH bytes are stored. Once settled, it is low exactly when DEPTH bytes are stored.
- R10: While `rd_oe_n` is high, `rd_data` is high impedance. While it is low, `rd_data` drives the output register.
- R11: With unrelated clock periods and random enables on both sides, every byte read matches the byte written in the same position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous reset, active low, shared by both domains |
| wr_clk | input | 1 | Write clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 8 | Byte to store |
| full_n | output | 1 | Low when full (write domain) |
| afull_n | output | 1 | Low when the level is DEPTH-7 or more (write domain) |
| rd_clk | input | 1 | Read clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| rd_data | output | 8 | Output register, three-state |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low when the level is 7 or less (read domain) |

## Verification
A pointer that skips or repeats shows up at the output on the very next read clock, as a byte that is out of order or duplicated. A write that gets past the full flag corrupts the oldest unread byte, and that becomes visible when the buffer is drained. A wrong flag offset or a broken pointer crossing shows up in two ways. Either a flag claims data or room that the true level denies, which is seen on the next edge. Or a flag still disagrees with the true level a few cycles after the other side has gone idle, and the bench compares every flag against the true level at that point.

// File: rtl/async_byte_fifo.sv
module async_byte_fifo #(
  parameter int DEPTH = 64
) (
  input  logic       rst_n,
  input  logic       wr_clk,
  input  logic       wr_en_n,
  input  logic [7:0] wr_data,
  output logic       full_n,
  output logic       afull_n,
  input  logic       rd_clk,
  input  logic       rd_en_n,
  input  logic       rd_oe_n,
  output wire  [7:0] rd_data,
  output logic       empty_n,
  output logic       aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] LVL_AF   = (AW+1)'(DEPTH - 7);
  localparam logic [AW:0] LVL_AE   = (AW+1)'(7);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [7:0] mem [DEPTH];

  // write domain
  logic [AW:0] wbin, wgray, rq1, rq2, wlevel, wbin_nx;
  logic        wr_ok;

  assign wr_ok   = !wr_en_n && full_n;
  assign wbin_nx = wbin + {{AW{1'b0}}, wr_ok};
  assign wlevel  = wbin - g2b(rq2);
  assign full_n  = (wlevel != LVL_FULL);
  assign afull_n = (wlevel < LVL_AF);

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= (wbin_nx >> 1) ^ wbin_nx;
      rq1   <= rgray;
      rq2   <= rq1;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_ok) mem[wbin[AW-1:0]] <= wr_data;
  end

  // read domain
  logic [AW:0] rbin, rgray, wq1, wq2, rlevel, rbin_nx;
  logic [7:0]  q;
  logic        rd_ok;

  assign rd_ok    = !rd_en_n && empty_n;
  assign rbin_nx  = rbin + {{AW{1'b0}}, rd_ok};
  assign rlevel   = g2b(wq2) - rbin;
  assign empty_n  = (rlevel != '0);
  assign aempty_n = (rlevel > LVL_AE);
  assign rd_data  = rd_oe_n ? 8'bz : q;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
      q     <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= (rbin_nx >> 1) ^ rbin_nx;
      wq1   <= wgray;
      wq2   <= wq1;
      if (rd_ok) q <= mem[rbin[AW-1:0]];
    end
  end

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wbin)); // R2
  AST_FULL_IMPLIES_AFULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n); // R8
  AST_WLEVEL_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wlevel <= LVL_FULL); // R9
  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin) && $stable(q)); // R3
  AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n); // R7
  AST_OUT_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_en_n |=> $stable(q)); // R4
endmodule

// File: tb/tb_async_byte_fifo.sv
`timescale 1ns/1ps
module tb_async_byte_fifo;
  localparam int DEPTH = 64;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_en_n = 1, rd_en_n = 1, rd_oe_n = 0;
  logic [7:0] wr_data = 0;
  wire  [7:0] rd_data;
  wire full_n, afull_n, empty_n, aempty_n;

  int total = 0, bad = 0, count = 0;
  logic [7:0] model[$];
  logic [7:0] last_exp = 0;
  bit w_go = 0, r_go = 0;

  async_byte_fifo #(.DEPTH(DEPTH)) dut (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .full_n(full_n), .afull_n(afull_n), .rd_clk(rd_clk), .rd_en_n(rd_en_n),
    .rd_oe_n(rd_oe_n), .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n));

  always #5 wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge wr_clk) if (w_go) begin model.push_back(wr_data); count++; end
  always @(posedge rd_clk) if (r_go) begin
    if (model.size() == 0) chk(0, "R3 read accepted while empty", 0, 1);
    else begin last_exp = model.pop_front(); count--; end
  end

  always @(negedge rd_clk) if (rst_n) begin
    chk(!(empty_n && count == 0), "R6 empty_n high on empty", count, 1);
    chk(!(aempty_n && count <= 7), "R7 aempty_n high at low level", count, 8);
    if (rd_oe_n) chk(rd_data === 8'bz, "R10 bus not high-Z", rd_data, 0);
    else chk(rd_data === last_exp, "R11 R4 output data", rd_data, last_exp);
  end
  always @(negedge wr_clk) if (rst_n) begin
    chk(!(full_n && count >= DEPTH), "R9 full_n high when full", count, DEPTH - 1);
    chk(!(afull_n && count >= DEPTH - 7), "R8 afull_n high at high level", count, DEPTH - 8);
  end

  task automatic wcyc(input bit en, input logic [7:0] d);
    @(negedge wr_clk);
    wr_en_n = !en; wr_data = d; w_go = en && full_n;
  endtask
  task automatic rcyc(input bit en);
    @(negedge rd_clk);
    rd_en_n = !en; r_go = en && empty_n;
  endtask
  task automatic settle();
    wcyc(0, 0); rcyc(0);
    repeat (8) @(negedge rd_clk);
  endtask
  task automatic exact();
    @(negedge rd_clk);
    chk(empty_n == (count != 0), "R6 settled empty_n", empty_n, count != 0);
    chk(aempty_n == (count > 7), "R7 settled aempty_n", aempty_n, count > 7);
    chk(full_n == (count < DEPTH), "R9 settled full_n", full_n, count < DEPTH);
    chk(afull_n == (count < DEPTH - 7), "R8 settled afull_n", afull_n, count < DEPTH - 7);
  endtask
  task automatic do_reset();
    @(negedge wr_clk);
    rst_n = 0; w_go = 0; r_go = 0; wr_en_n = 1; rd_en_n = 1;
    model.delete(); count = 0; last_exp = 0;
    #3;
    chk(!empty_n && !aempty_n && full_n && afull_n, "R5 reset flags",
        {empty_n, aempty_n, full_n, afull_n}, 4'b0011);
    chk(rd_data === 8'h00, "R5 R4 output after reset", rd_data, 0);
    #20 rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    settle(); exact();
    for (int i = 0; i < 7; i++) wcyc(1, 8'(i + 1));
    settle(); exact();
    chk(!aempty_n, "R7 level 7", aempty_n, 0);
    wcyc(1, 8'h08);
    settle(); exact();
    chk(aempty_n, "R7 level 8", aempty_n, 1);
    for (int i = 8; i < DEPTH - 8; i++) wcyc(1, 8'(i + 1));
    settle(); exact();
    chk(afull_n, "R8 level DEPTH-8", afull_n, 1);
    wcyc(1, 8'hA5);
    settle(); exact();
    chk(!afull_n, "R8 level DEPTH-7", afull_n, 0);
    for (int i = 0; i < 12; i++) wcyc(1, 8'(8'hC0 + i));
    settle(); exact();
    chk(count == DEPTH, "R2 R1 writes past full ignored", count, DEPTH);
    chk(!full_n, "R9 full at DEPTH", full_n, 0);
    for (int i = 0; i < DEPTH + 5; i++) rcyc(1);
    settle(); exact();
    chk(count == 0, "R3 drained", count, 0);
    repeat (5) rcyc(1);
    settle();
    chk(rd_data === last_exp, "R4 hold after empty reads", rd_data, last_exp);
    rd_oe_n = 1;
    repeat (3) @(negedge rd_clk);
    chk(rd_data === 8'bz, "R10 high-Z", rd_data, 0);
    rd_oe_n = 0;
    repeat (2) @(negedge rd_clk);
    fork
      begin for (int i = 0; i < 3000; i++) wcyc(($urandom % 3) != 0, 8'($urandom)); wcyc(0, 0); end
      begin for (int i = 0; i < 2500; i++) rcyc(($urandom % 2) != 0); rcyc(0); end
    join
    settle(); exact();
    fork
      begin for (int i = 0; i < 2000; i++) wcyc(($urandom % 3) == 0, 8'($urandom)); wcyc(0, 0); end
      begin for (int i = 0; i < 2000; i++) rcyc(($urandom % 4) != 0); rcyc(0); end
    join
    settle(); exact();
    for (int i = 0; i < DEPTH + 10; i++) rcyc(1);
    settle(); exact();
    for (int i = 0; i < 20; i++) wcyc(1, 8'($urandom));
    settle();
    do_reset();
    settle(); exact();
    for (int i = 0; i < 3; i++) wcyc(1, 8'(8'h30 + i));
    settle();
    for (int i = 0; i < 3; i++) rcyc(1);
    settle(); exact();
    chk(last_exp == 8'h32, "R1 order after reset", last_exp, 8'h32);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule